// File: doc/BRIEF.md
# Address/Data Window Configuration Intercept

This block sits on the register path between a host bus and a device that exposes an indirect address/data register pair. Host accesses normally flow through to the device unchanged. A value written to the indirect address register is compared against a small table of match/mask entries. When an entry hits, a window opens: accesses to the indirect data register are then served from a local 4 KB shadow of configuration space, at the offset formed by the masked bits of the address value, and the device does not see them.

Two further device registers, a master register and an enable register, form a gate. The intercept acts only while bit 0 of both is set. Writes to either register still reach the device, and the block keeps its own copy of bit 0. While the gate is closed, every access passes through and address writes leave the window state alone. The match table is loaded through a separate setup port and is invalid after reset.

Top module: `cfg_window_intercept`

## Requirements
- R1: After reset the window is closed, the gate is off and every match entry is invalid, so a data-register read returns device data and a data-register write reaches the device, even after the gate is opened and a previously matching value is written to the address register.
- R2: A host access to any offset other than the data register (default 0x0C) is presented to the device in the same cycle with unchanged address, direction, data and byte enables.
- R3: A write to the address register (default 0x08) is always forwarded unchanged, and with the gate on it closes the window when no valid entry matches.
- R4: With the gate on, an address write with value V opens the window when (V & ~mask) == match for a valid entry; the shadow byte offset becomes V & mask, and the shadow word used is that offset divided by 4 (the low two offset bits are ignored).
- R5: When several valid entries match, the entry with the lowest index sets the offset.
- R6: A data-register read is always forwarded to the device; when the window is open and the gate on, the returned data is the shadow word instead of the device data.
- R7: A data-register write with the window open and the gate on is not forwarded; it updates the shadow word, only in the byte lanes whose enable bit is set (bit n covers data bits 8n+7..8n).
- R8: A data-register write with the window closed is forwarded to the device.
- R9: The gate is on only while the last written bit 0 of the master register (offset 0x00) and of the enable register (offset 0x04) are both 1; those bits update only when byte enable 0 is set. With the gate off, data accesses pass through and address writes do not change the window, which keeps its state for when the gate reopens.
- R10: An entry whose valid bit is clear never matches.
- R11: Read data and its valid flag appear in the cycle after the read request; writes produce no valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request, one cycle per access |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | AW | Host register byte offset |
| h_wdata | input | DW | Host write data |
| h_be | input | DW/8 | Host byte enables |
| h_rvalid | output | 1 | Read data valid, one cycle after a read |
| h_rdata | output | DW | Read data to host |
| d_req | output | 1 | Device access request |
| d_we | output | 1 | Device write flag |
| d_addr | output | AW | Device register offset |
| d_wdata | output | DW | Device write data |
| d_be | output | DW/8 | Device byte enables |
| d_rdata | input | DW | Device read data, valid the cycle after a device read |
| ent_we | input | 1 | Setup write of one match entry |
| ent_idx | input | IW | Entry index for the setup write |
| ent_valid | input | 1 | Valid bit to store |
| ent_match | input | DW | Match value to store |
| ent_mask | input | DW | Mask value to store |

## Verification
The bench targets the gate interplay: an address write made while the gate is off must not open the window, and a window opened before the gate is dropped must still be open when it returns; a design that tracked the window regardless of the gate, or cleared it with the gate, returns the wrong source. A lane-0-less write to the enable register must leave the gate on, otherwise shadow reads turn into device reads. Overlapping entries with different masks expose a wrong priority order as a different shadow word, two entries aliasing one shadow word show whether the offset is masked correctly, and a reset in the middle of an open window must leave both the window and the table cleared.

// File: rtl/cfg_window_intercept.sv
module cfg_window_intercept #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NUM_ENT = 2,
  parameter int CFG_BYTES = 4096,
  parameter bit GATED = 1'b1,
  parameter logic [AW-1:0] MASTER_OFS = 'h00,
  parameter logic [AW-1:0] ENABLE_OFS = 'h04,
  parameter logic [AW-1:0] ADDR_OFS = 'h08,
  parameter logic [AW-1:0] DATA_OFS = 'h0C,
  localparam int BEW = DW / 8,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_req,
  input  logic           h_we,
  input  logic [AW-1:0]  h_addr,
  input  logic [DW-1:0]  h_wdata,
  input  logic [BEW-1:0] h_be,
  output logic           h_rvalid,
  output logic [DW-1:0]  h_rdata,
  output logic           d_req,
  output logic           d_we,
  output logic [AW-1:0]  d_addr,
  output logic [DW-1:0]  d_wdata,
  output logic [BEW-1:0] d_be,
  input  logic [DW-1:0]  d_rdata,
  input  logic           ent_we,
  input  logic [IW-1:0]  ent_idx,
  input  logic           ent_valid,
  input  logic [DW-1:0]  ent_match,
  input  logic [DW-1:0]  ent_mask
);
  localparam int WORDS = CFG_BYTES / BEW;
  localparam int WIW = $clog2(WORDS);
  localparam int BSH = $clog2(BEW);

  logic [DW-1:0]      m_match [NUM_ENT];
  logic [DW-1:0]      m_mask  [NUM_ENT];
  logic [NUM_ENT-1:0] m_vld;

  logic           win_open;
  logic [WIW-1:0] win_word;
  logic           gate;
  logic           hit;
  logic [WIW-1:0] hit_word;

  logic [DW-1:0]  shadow [WORDS];
  logic [DW-1:0]  shadow_q;
  logic           rvalid_q;
  logic           sel_q;

  wire addr_wr  = h_req & h_we & (h_addr == ADDR_OFS);
  wire data_acc = h_req & (h_addr == DATA_OFS);
  wire steer    = gate & win_open;
  wire sh_wr    = data_acc & h_we & steer;
  wire sh_rd    = data_acc & ~h_we & steer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= '0;
    end else if (ent_we) begin
      m_vld[ent_idx] <= ent_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_we) begin
      m_match[ent_idx] <= ent_match;
      m_mask[ent_idx]  <= ent_mask;
    end
  end

  always_comb begin
    hit = 1'b0;
    hit_word = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (m_vld[i] && ((h_wdata & ~m_mask[i]) == m_match[i])) begin
        hit = 1'b1;
        hit_word = WIW'((h_wdata & m_mask[i]) >> BSH);
      end
    end
  end

  generate
    if (GATED) begin : g_gate
      logic master_q, enable_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          master_q <= 1'b0;
          enable_q <= 1'b0;
        end else if (h_req && h_we && h_be[0]) begin
          if (h_addr == MASTER_OFS) master_q <= h_wdata[0];
          if (h_addr == ENABLE_OFS) enable_q <= h_wdata[0];
        end
      end
      assign gate = master_q & enable_q;
    end else begin : g_open
      assign gate = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_word <= '0;
    end else if (addr_wr && gate) begin
      win_open <= hit;
      win_word <= hit_word;
    end
  end

  always_ff @(posedge clk) begin
    if (sh_wr) begin
      for (int b = 0; b < BEW; b++) begin
        if (h_be[b]) shadow[win_word][b*8 +: 8] <= h_wdata[b*8 +: 8];
      end
    end
    if (sh_rd) shadow_q <= shadow[win_word];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      rvalid_q <= h_req & ~h_we;
      sel_q    <= sh_rd;
    end
  end

  assign d_req   = h_req & ~sh_wr;
  assign d_we    = h_we;
  assign d_addr  = h_addr;
  assign d_wdata = h_wdata;
  assign d_be    = h_be;

  assign h_rvalid = rvalid_q;
  assign h_rdata  = sel_q ? shadow_q : d_rdata;
endmodule

// File: rtl/cfg_window_intercept_chk.sv
module cfg_window_intercept_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] ADDR_OFS = 'h08,
  parameter logic [AW-1:0] DATA_OFS = 'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req,
  input logic          h_we,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_wdata,
  input logic          h_rvalid,
  input logic          d_req,
  input logic          d_we,
  input logic [AW-1:0] d_addr,
  input logic [DW-1:0] d_wdata,
  input logic          win_open,
  input logic          gate
);
  a_r1_closed_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !win_open && !gate);

  a_r2_other_offsets_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_addr != DATA_OFS) |-> (d_req && d_we == h_we && d_addr == h_addr && d_wdata == h_wdata));

  a_r3_addr_write_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_we && h_addr == ADDR_OFS) |-> (d_req && d_wdata == h_wdata));

  a_r6_read_always_issued: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we) |-> d_req);

  a_r7_open_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_we && h_addr == DATA_OFS && win_open && gate) |-> !d_req);

  a_r9_gate_off_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !gate) |-> d_req);

  a_r9_gate_off_window_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !$past(!rst_n)) |=> $stable(win_open) || gate);

  a_r11_read_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we) |=> h_rvalid);

  a_r11_no_valid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req && !h_we) |=> !h_rvalid);
endmodule

bind cfg_window_intercept cfg_window_intercept_chk #(
  .AW(AW), .DW(DW), .ADDR_OFS(ADDR_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
  .h_wdata(h_wdata), .h_rvalid(h_rvalid), .d_req(d_req), .d_we(d_we),
  .d_addr(d_addr), .d_wdata(d_wdata), .win_open(win_open), .gate(gate)
);

// File: tb/cfg_window_intercept_tb.sv
module cfg_window_intercept_tb;
  localparam int CLK_P = 10;
  localparam int NV = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [3:0]  h_be = '0;
  logic        h_rvalid;
  logic [31:0] h_rdata;
  logic        d_req, d_we;
  logic [7:0]  d_addr;
  logic [31:0] d_wdata;
  logic [3:0]  d_be;
  logic [31:0] d_rdata = '0;
  logic        ent_we = 1'b0;
  logic [0:0]  ent_idx = '0;
  logic        ent_valid = 1'b0;
  logic [31:0] ent_match = '0, ent_mask = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (d_req && !d_we) d_rdata <= {24'hDEAD00, d_addr};

  cfg_window_intercept u_dut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_be(h_be), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_be(d_be),
    .d_rdata(d_rdata), .ent_we(ent_we), .ent_idx(ent_idx), .ent_valid(ent_valid),
    .ent_match(ent_match), .ent_mask(ent_mask)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  ad;
    logic [31:0] wd;
    logic [3:0]  be;
    logic        fwd;
    logic [31:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h08, 32'h0000_1804, 4'hF, 1'b1, 32'h0, 4'd9},   // R9 gate off: no open
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hDEAD_000C, 4'd9},
    '{1'b1, 8'h00, 32'h1,         4'hF, 1'b1, 32'h0, 4'd9},
    '{1'b1, 8'h04, 32'h1,         4'hF, 1'b1, 32'h0, 4'd9},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hDEAD_000C, 4'd9},
    '{1'b1, 8'h08, 32'h0000_1804, 4'hF, 1'b1, 32'h0, 4'd4},   // R4 open entry 0
    '{1'b1, 8'h0C, 32'hCAFE_F00D, 4'hF, 1'b0, 32'h0, 4'd7},   // R7
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hCAFE_F00D, 4'd6}, // R6
    '{1'b1, 8'h0C, 32'h0000_00AA, 4'h1, 1'b0, 32'h0, 4'd7},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hCAFE_F0AA, 4'd7},
    '{1'b1, 8'h08, 32'h0008_8010, 4'hF, 1'b1, 32'h0, 4'd4},   // entry 1
    '{1'b1, 8'h0C, 32'h1234_5678, 4'hF, 1'b0, 32'h0, 4'd7},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'h1234_5678, 4'd4},
    '{1'b1, 8'h08, 32'h0008_8004, 4'hF, 1'b1, 32'h0, 4'd4},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hCAFE_F0AA, 4'd4},
    '{1'b1, 8'h08, 32'h0000_2000, 4'hF, 1'b1, 32'h0, 4'd3},   // R3 miss closes
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hDEAD_000C, 4'd3},
    '{1'b1, 8'h0C, 32'h0000_0005, 4'hF, 1'b1, 32'h0, 4'd8},   // R8
    '{1'b0, 8'h10, 32'h0,         4'hF, 1'b1, 32'hDEAD_0010, 4'd2}, // R2
    '{1'b1, 8'h08, 32'h0000_1810, 4'hF, 1'b1, 32'h0, 4'd4},
    '{1'b1, 8'h00, 32'h0,         4'hF, 1'b1, 32'h0, 4'd9},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hDEAD_000C, 4'd9},
    '{1'b1, 8'h00, 32'h1,         4'hF, 1'b1, 32'h0, 4'd9},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'h1234_5678, 4'd9},
    '{1'b1, 8'h04, 32'h0,         4'h2, 1'b1, 32'h0, 4'd9},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'h1234_5678, 4'd9},
    '{1'b1, 8'h04, 32'h2,         4'hF, 1'b1, 32'h0, 4'd9},
    '{1'b0, 8'h0C, 32'h0,         4'hF, 1'b1, 32'hDEAD_000C, 4'd9}
  };

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] wd, input logic [3:0] be,
                     output logic fwd, output logic fwd_ok, output logic rv, output logic [31:0] rd);
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = a; h_wdata = wd; h_be = be;
    #1;
    fwd = d_req;
    fwd_ok = (d_addr == a) && (d_we == we) && (d_wdata == wd) && (d_be == be);
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0;
    rv = h_rvalid;
    rd = h_rdata;
  endtask

  task automatic set_ent(input logic idx, input logic v, input logic [31:0] m, input logic [31:0] k);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = idx; ent_valid = v; ent_match = m; ent_mask = k;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    logic f, fo, rv;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check(h_rvalid == 1'b0, "R1 rvalid in reset", {31'b0, h_rvalid}, 32'h0);
    rst_n = 1'b1;

    // R1: fresh reset, data register passes through both ways
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'hDEAD_000C, "R1 read after reset", rd, 32'hDEAD_000C);
    check(rv == 1'b1, "R11 read valid", {31'b0, rv}, 32'h1);
    acc(1'b1, 8'h0C, 32'h77, 4'hF, f, fo, rv, rd);
    check(f == 1'b1, "R1 write forwarded after reset", {31'b0, f}, 32'h1);

    set_ent(1'b0, 1'b1, 32'h0000_1800, 32'h0000_00FF);
    set_ent(1'b1, 1'b1, 32'h0008_8000, 32'h0000_0FFF);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].we, VEC[i].ad, VEC[i].wd, VEC[i].be, f, fo, rv, rd);
      check(f == VEC[i].fwd, $sformatf("R%0d vec %0d forward", VEC[i].rq, i), {31'b0, f}, {31'b0, VEC[i].fwd});
      if (f) check(fo, $sformatf("R2 vec %0d fields unchanged", i), {31'b0, fo}, 32'h1);
      check(rv == !VEC[i].we, $sformatf("R11 vec %0d rvalid", i), {31'b0, rv}, {31'b0, !VEC[i].we});
      if (!VEC[i].we)
        check(rd == VEC[i].rd, $sformatf("R%0d vec %0d rdata", VEC[i].rq, i), rd, VEC[i].rd);
    end

    // R5: overlapping entries, lowest index wins
    acc(1'b1, 8'h04, 32'h1, 4'hF, f, fo, rv, rd);
    set_ent(1'b0, 1'b1, 32'h0000_0100, 32'h0000_00FF);
    set_ent(1'b1, 1'b1, 32'h0000_0000, 32'h0000_01FF);
    acc(1'b1, 8'h08, 32'h0000_0104, 4'hF, f, fo, rv, rd);
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'hCAFE_F0AA, "R5 first hit wins", rd, 32'hCAFE_F0AA);

    // R10: invalid entry 0 is skipped, entry 1 maps to another word
    set_ent(1'b0, 1'b0, 32'h0000_0100, 32'h0000_00FF);
    acc(1'b1, 8'h08, 32'h0000_0104, 4'hF, f, fo, rv, rd);
    acc(1'b1, 8'h0C, 32'h0BAD_BEEF, 4'hF, f, fo, rv, rd);
    check(f == 1'b0, "R10 entry 1 opened window", {31'b0, f}, 32'h0);
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'h0BAD_BEEF, "R10 entry 1 offset", rd, 32'h0BAD_BEEF);
    set_ent(1'b0, 1'b1, 32'h0000_0100, 32'h0000_00FF);
    acc(1'b1, 8'h08, 32'h0000_0104, 4'hF, f, fo, rv, rd);
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'hCAFE_F0AA, "R10 other word untouched", rd, 32'hCAFE_F0AA);
    set_ent(1'b0, 1'b0, 32'h0000_0100, 32'h0000_00FF);
    set_ent(1'b1, 1'b0, 32'h0000_0000, 32'h0000_01FF);
    acc(1'b1, 8'h08, 32'h0000_0104, 4'hF, f, fo, rv, rd);
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'hDEAD_000C, "R10 all invalid no open", rd, 32'hDEAD_000C);

    // R1: reset while window open clears window, gate and table
    set_ent(1'b0, 1'b1, 32'h0000_0100, 32'h0000_00FF);
    acc(1'b1, 8'h08, 32'h0000_0104, 4'hF, f, fo, rv, rd);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'hDEAD_000C, "R1 reset closes window", rd, 32'hDEAD_000C);
    acc(1'b1, 8'h00, 32'h1, 4'hF, f, fo, rv, rd);
    acc(1'b1, 8'h04, 32'h1, 4'hF, f, fo, rv, rd);
    acc(1'b1, 8'h08, 32'h0000_0104, 4'hF, f, fo, rv, rd);
    acc(1'b1, 8'h0C, 32'h99, 4'hF, f, fo, rv, rd);
    check(f == 1'b1, "R1 table invalid after reset", {31'b0, f}, 32'h1);
    acc(1'b0, 8'h0C, 32'h0, 4'hF, f, fo, rv, rd);
    check(rd == 32'hDEAD_000C, "R1 read after table reset", rd, 32'hDEAD_000C);

    finish_up();
  end
endmodule